// File: doc/BRIEF.md
# Iterative Radix-4 Booth Multiply-Accumulate Unit

This block computes the low word of a product, optionally with a third operand added in. The supported forms are `A*B` and `A*B+C`, with the result taken modulo 2^W. It uses one adder and processes two multiplier bits per clock. The multiplier is recoded into signed radix-4 digits, so a step adds or subtracts either one or two times the multiplicand. A multiply stops as soon as no set multiplier bits and no pending correction remain. Short multipliers therefore finish in fewer cycles than long ones.

Software or a pipeline front end waits for `ready` and then pulses `start` with the operands. It then waits for the one-cycle `done` pulse. The result is returned truncated to W bits. Because of this, the same hardware serves signed and unsigned operands.

Top module: `booth_mac`

## Requirements
- R1: With `acc_en` low, the `result` presented with `done` equals `(op_a * op_b) mod 2^W` for the operands captured at acceptance.
- R2: With `acc_en` high, the `result` presented with `done` equals `(op_a * op_b + op_c) mod 2^W`.
- R3: The result bits are identical whether operands are read as two's-complement or unsigned. For example, (-3)*(-5) yields 15, and 0x80000000*0xFFFFFFFF yields 0x80000000.
- R4: `start` is accepted at a rising edge where `ready` is high. `done` rises N edges later. N = 1 when `op_b` is 0. Otherwise N = min(W/2, floor((m+1)/2)+1), where m is the index of the highest set bit of `op_b`. N never exceeds W/2 (16).
- R5: `done` is high for exactly one cycle per operation, and `result` changes only in the cycle `done` is high.
- R6: `ready` is low from the edge after acceptance until `done`. A `start` pulse while `ready` is low does not alter the running operation's result or timing.
- R7: After reset, `ready` is 1, `done` is 0 and `result` is 0.
- R8: A multiplier whose top set bit sits at an odd index still pays one extra step for the negative digit's correction. For example, op_b = 2 takes 2 steps and op_b = 1 takes 1 step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released synchronously |
| start | input | 1 | Request a new operation (taken only when ready) |
| op_a | input | W | Multiplicand |
| op_b | input | W | Multiplier |
| op_c | input | W | Accumulate addend |
| acc_en | input | 1 | 1: add op_c to the product, 0: plain product |
| ready | output | 1 | Unit idle and able to accept start |
| done | output | 1 | One-cycle pulse: result is valid |
| result | output | W | Low W bits of the product (plus addend) |

## Verification
The bench targets multipliers whose top set bit is at an odd position, such as 2, 0x2000_0000 and all-ones. A design that exits once the remaining bits are zero, without checking the pending borrow, returns a result short by 4^k times the multiplicand and finishes one step early. Mixed-sign and 0x80000000 operands expose a design that sign-extends the shifted multiplier or mishandles the negated doubled multiplicand. Exact latency is checked for every operation, so a missing or extra iteration shows up even when the value happens to match. A second `start` is injected mid-operation: a unit that re-arms would return the injected product instead of the original one.

// File: rtl/booth_mac_pkg.sv
package booth_mac_pkg;
  // Signed radix-4 digit selected by one recoded multiplier triplet.
  typedef enum logic [2:0] {
    DIG_ZERO = 3'd0,
    DIG_P1   = 3'd1,
    DIG_P2   = 3'd2,
    DIG_N1   = 3'd3,
    DIG_N2   = 3'd4
  } booth_dig_e;
endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_mac_pkg::*;
(
  input  logic [2:0]  trip,   // {b[2i+1], b[2i], b[2i-1]}
  output booth_dig_e  dig
);
  always_comb begin
    unique case (trip)
      3'b000, 3'b111: dig = DIG_ZERO;
      3'b001, 3'b010: dig = DIG_P1;
      3'b011:         dig = DIG_P2;
      3'b100:         dig = DIG_N2;
      default:        dig = DIG_N1;   // 101, 110
    endcase
  end
endmodule

// File: rtl/booth_addend.sv
module booth_addend
  import booth_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  booth_dig_e     dig,
  input  logic [W-1:0]   mcand,
  output logic [W-1:0]   addend
);
  logic [W-1:0] mag;
  logic         neg;

  always_comb begin
    mag = '0;
    neg = 1'b0;
    unique case (dig)
      DIG_P1: mag = mcand;
      DIG_P2: mag = {mcand[W-2:0], 1'b0};
      DIG_N1: begin mag = mcand;                  neg = 1'b1; end
      DIG_N2: begin mag = {mcand[W-2:0], 1'b0};   neg = 1'b1; end
      default: mag = '0;
    endcase
    addend = neg ? (~mag + W'(1)) : mag;
  end
endmodule

// File: rtl/booth_mac.sv
module booth_mac
  import booth_mac_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [W-1:0] op_c,
  input  logic         acc_en,
  output logic         ready,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int STEPS = W / 2;
  localparam int CW    = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST_STEP = CW'(STEPS - 1);

  // reset synchronizer: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [W-1:0]  acc_q, acc_d;
  logic [W-1:0]  mcand_q, mcand_d;
  logic [W-1:0]  mplier_q, mplier_d;
  logic          prev_q, prev_d;
  logic [CW-1:0] step_q, step_d;
  logic [W-1:0]  result_q, result_d;

  booth_dig_e    dig;
  logic [W-1:0]  addend;
  logic [W-1:0]  acc_sum;
  logic [W-1:0]  mplier_sh;
  logic          finish;
  logic          dp_en;

  booth_recoder u_rec (
    .trip ({mplier_q[1:0], prev_q}),
    .dig  (dig)
  );

  booth_addend #(.W(W)) u_add (
    .dig    (dig),
    .mcand  (mcand_q),
    .addend (addend)
  );

  assign acc_sum   = acc_q + addend;
  assign mplier_sh = {2'b00, mplier_q[W-1:2]};
  // stop when nothing is left to consume and no borrow is pending,
  // or when every digit has been processed
  assign finish    = ((mplier_sh == '0) && !mplier_q[1]) || (step_q == LAST_STEP);
  assign dp_en     = busy_q | start;

  always_comb begin
    busy_d   = busy_q;
    done_d   = 1'b0;
    acc_d    = acc_q;
    mcand_d  = mcand_q;
    mplier_d = mplier_q;
    prev_d   = prev_q;
    step_d   = step_q;
    result_d = result_q;
    if (!busy_q) begin
      if (start) begin
        busy_d   = 1'b1;
        acc_d    = acc_en ? op_c : '0;
        mcand_d  = op_a;
        mplier_d = op_b;
        prev_d   = 1'b0;
        step_d   = '0;
      end
    end else begin
      acc_d    = acc_sum;
      mcand_d  = {mcand_q[W-3:0], 2'b00};
      mplier_d = mplier_sh;
      prev_d   = mplier_q[1];
      step_d   = step_q + CW'(1);
      if (finish) begin
        busy_d   = 1'b0;
        done_d   = 1'b1;
        result_d = acc_sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      busy_q   <= busy_d;
      done_q   <= done_d;
      if (done_d) result_q <= result_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      acc_q    <= '0;
      mcand_q  <= '0;
      mplier_q <= '0;
      prev_q   <= 1'b0;
      step_q   <= '0;
    end else if (dp_en) begin
      acc_q    <= acc_d;
      mcand_q  <= mcand_d;
      mplier_q <= mplier_d;
      prev_q   <= prev_d;
      step_q   <= step_d;
    end
  end

  assign ready  = ~busy_q;
  assign done   = done_q;
  assign result = result_q;
endmodule

// File: rtl/booth_mac_chk.sv
module booth_mac_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         ready,
  input logic         done,
  input logic [W-1:0] result
);
  localparam int STEPS = W / 2;
  localparam int CW    = $clog2(STEPS + 2) + 1;

  logic [CW-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_cnt <= '0;
    else if (ready)  busy_cnt <= '0;
    else if (busy_cnt != '1) busy_cnt <= busy_cnt + CW'(1);
  end

  a_r4_max_steps: assert property (@(posedge clk) disable iff (!rst_n)
    busy_cnt <= CW'(STEPS));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  a_r6_accept_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ready) |=> !ready);

  a_r6_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ready && $past(!ready)));
endmodule

bind booth_mac booth_mac_chk #(.W(W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .ready  (ready),
  .done   (done),
  .result (result)
);

// File: tb/booth_mac_test.sv
`timescale 1ns/1ps
module booth_mac_test;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [W-1:0] op_a, op_b, op_c;
  logic         acc_en;
  logic         ready, done;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;   // 125 MHz

  booth_mac #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .op_a(op_a), .op_b(op_b), .op_c(op_c), .acc_en(acc_en),
    .ready(ready), .done(done), .result(result)
  );

  function automatic logic [W-1:0] exp_val(input logic [W-1:0] a, b, c, input logic en);
    logic [2*W-1:0] p;
    p = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    return p[W-1:0] + (en ? c : '0);
  endfunction

  function automatic int exp_steps(input logic [W-1:0] b);
    int m = -1;
    int n;
    for (int i = 0; i < W; i++) if (b[i]) m = i;
    if (m < 0) return 1;
    n = (m + 1) / 2 + 1;
    return (n > W/2) ? W/2 : n;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, b, c, input logic en,
                        input string req, input bit inject);
    logic [W-1:0] ev;
    int en_steps, n;
    bit seen;
    ev = exp_val(a, b, c, en);
    en_steps = exp_steps(b);
    while (!ready) @(negedge clk);
    op_a = a; op_b = b; op_c = c; acc_en = en; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    op_a = ~a; op_b = b ^ 32'h5A5A_0001; op_c = ~c; acc_en = ~en;
    chk(!ready, "R6 ready low after accept", W'(ready), '0);
    n = 0; seen = 0;
    while (n < 40 && !seen) begin
      @(negedge clk);
      n++;
      if (inject && n == 1 && !done) start = 1'b1;
      else start = 1'b0;
      if (done) seen = 1;
    end
    start = 1'b0;
    chk(seen, {req, " done seen"}, W'(seen), 1);
    chk(result == ev, req, result, ev);
    chk(n == en_steps, "R4/R8 latency", W'(n), W'(en_steps));
    @(negedge clk);
    chk(!done, "R5 done single cycle", W'(done), '0);
    chk(result == ev, "R5 result held", result, ev);
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] ra, rb, rc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0; op_c = '0; acc_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk(ready == 1'b1, "R7 ready after reset", W'(ready), 1);
    chk(done == 1'b0, "R7 done after reset", W'(done), 0);
    chk(result == '0, "R7 result after reset", result, '0);

    // directed corners
    run_op(32'd7, 32'd0, 32'd0, 1'b0, "R1 zero multiplier", 0);
    run_op(32'd9, 32'd1, 32'd0, 1'b0, "R8 b=1 one step", 0);
    run_op(32'd9, 32'd2, 32'd0, 1'b0, "R8 b=2 correction step", 0);
    run_op(32'd9, 32'd3, 32'd0, 1'b0, "R8 b=3", 0);
    run_op(32'h1234_5678, 32'h2000_0000, 32'd0, 1'b0, "R8 odd top bit", 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 1'b0, "R1 all ones", 0);
    run_op(32'hFFFF_FFFD, 32'hFFFF_FFFB, 32'd0, 1'b0, "R3 (-3)*(-5)", 0);
    run_op(32'h8000_0000, 32'hFFFF_FFFF, 32'd0, 1'b0, "R3 0x80000000 by -1", 0);
    run_op(32'hFFFF_FFF9, 32'd6, 32'd0, 1'b0, "R3 negative by small", 0);
    run_op(32'h0000_0011, 32'h8000_0000, 32'h0000_0100, 1'b1, "R2 top bit multiplier", 0);
    run_op(32'hDEAD_BEEF, 32'd0, 32'hCAFE_F00D, 1'b1, "R2 accumulate only", 0);
    run_op(32'h0001_0003, 32'h0000_7FFF, 32'hFFFF_FFFF, 1'b1, "R2 wrap addend", 0);
    // R6 start during busy ignored
    run_op(32'h0BAD_F00D, 32'h00FF_00FF, 32'd5, 1'b1, "R6 mid-run start ignored", 1);
    run_op(32'h1357_9BDF, 32'hFFFF_0000, 32'd0, 1'b0, "R6 mid-run start ignored long", 1);

    // constrained random
    for (int k = 0; k < 200; k++) begin
      ra = $urandom();
      rb = $urandom() >> ($urandom() % W);
      rc = $urandom();
      if (k % 2 == 0) run_op(ra, rb, rc, 1'b1, "R2 random accumulate", (k % 7) == 0);
      else            run_op(ra, rb, rc, 1'b0, "R1 random multiply", (k % 7) == 1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule